// File: doc/BRIEF.md
# Cascaded 32-bit Capture Timer

Two 16-bit up/down counters that can be chained into a single 32-bit count. The lower counter steps on a prescaled tick in a direction set by a control bit. The upper counter either counts prescaled ticks of its own or, when its clock select field is set to the cascade code, follows the lower counter's carries: a wrap upward adds one to it and a wrap downward takes one away.

Each counter has a capture register. A capture is triggered by an edge on a capture source. Each capture pin first passes through a two-flop synchronizer. The edge polarity is selected per channel. A small capture control register can add the other channel's pin to a channel's source. The source is then the OR of both pins, so one external event latches both halves of the 32-bit count in the same clock.

All configuration goes through a single-cycle register write port. The counters and the capture registers are visible as output ports.

Top module: `cascade_capture_timer`

## Requirements
- R1: After reset both counters, both capture registers and all control registers are zero.
- R2: Address 0 is the lower control register: bits [2:0] clock select, bit 3 enable, bit 4 direction (0 up, 1 down), bits [6:5] edge mode. With enable set and select 0, the lower counter moves by one each clock and wraps modulo 2^16 in both directions.
- R3: A clock select value s makes a counter step once every 2^s clocks, using a free-running 7-bit prescaler shared by both channels. In any window of 4·2^s consecutive clocks there are exactly 4 steps.
- R4: Address 1 is the upper control register and uses the same layout as address 0. When its clock select is 3'b111 and its enable bit is set, a lower wrap from 0xFFFF to 0 increments the upper counter in the same clock, and a wrap from 0 to 0xFFFF decrements it.
- R5: In cascade mode the upper counter does not change in any clock without a lower wrap or a write.
- R6: A pin change set up before clock edge n is registered into the capture register at edge n+2. The value registered is the counter value held between edges n+1 and n+2. The capture register holds its value at all other times.
- R7: Edge mode 00 captures on rising edges, 01 on falling edges, and 10 or 11 on both. An edge of the other polarity leaves the capture register unchanged.
- R8: Address 4 is the capture control register. Bit 0 adds the upper pin to the lower channel's capture source. Bit 1 adds the lower pin to the upper channel's capture source. Each source is the OR of its enabled pins. With both bits set, one edge on either pin captures both counters in the same clock.
- R9: When a count step and a capture fall in the same clock, the capture holds the count from before the step.
- R10: Writes to address 2 and address 3 load the lower and upper counters. A load takes priority over any step in the same clock.
- R11: A counter whose enable bit is clear holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| cap_pin_lo | input | 1 | Lower channel capture pin (asynchronous) |
| cap_pin_hi | input | 1 | Upper channel capture pin (asynchronous) |
| cnt_lo | output | 16 | Lower counter |
| cnt_hi | output | 16 | Upper counter |
| cap_lo | output | 16 | Lower capture register |
| cap_hi | output | 16 | Upper capture register |

## Verification
A fault in carry propagation shows up at the upper counter in the same clock as the lower wrap. The bench checks the two halves together on both sides of each wrap. A wrong synchronizer depth or a wrong edge polarity moves or suppresses a capture. This shows as a capture value off by the number of clocks in error, or as a capture register that stays unchanged, within three clocks of the pin change. A wrong source OR shows as only one half being latched when both should be.

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer #(
  parameter int CW  = 16,
  parameter int PSW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          cap_pin_lo,
  input  logic          cap_pin_hi,
  output logic [CW-1:0] cnt_lo,
  output logic [CW-1:0] cnt_hi,
  output logic [CW-1:0] cap_lo,
  output logic [CW-1:0] cap_hi
);
  localparam logic [2:0] A_CTL_LO = 3'd0;
  localparam logic [2:0] A_CTL_HI = 3'd1;
  localparam logic [2:0] A_CNT_LO = 3'd2;
  localparam logic [2:0] A_CNT_HI = 3'd3;
  localparam logic [2:0] A_CAPCTL = 3'd4;
  localparam logic [2:0] SEL_CASC = 3'b111;

  logic [6:0]     ctl_lo, ctl_hi;
  logic [1:0]     cap_ctl;
  logic [PSW-1:0] pre;
  logic [1:0]     sy_lo, sy_hi;
  logic           prev_lo, prev_hi;

  function automatic logic tick(input logic [2:0] sel, input logic [PSW-1:0] p);
    logic [PSW-1:0] m;
    m = PSW'((32'd1 << sel) - 32'd1);
    return (p & m) == m;
  endfunction

  function automatic logic edge_hit(input logic [1:0] mode, input logic cur, input logic old);
    case (mode)
      2'b00:   return cur & ~old;
      2'b01:   return ~cur & old;
      default: return cur ^ old;
    endcase
  endfunction

  wire wr_cl = wr_en && wr_addr == A_CNT_LO;
  wire wr_ch = wr_en && wr_addr == A_CNT_HI;

  wire lo_step = ctl_lo[3] & tick(ctl_lo[2:0], pre);
  wire lo_ovf  = lo_step & ~ctl_lo[4] & (cnt_lo == '1);
  wire lo_udf  = lo_step &  ctl_lo[4] & (cnt_lo == '0);
  wire casc    = ctl_hi[2:0] == SEL_CASC;
  wire hi_tick = tick(ctl_hi[2:0], pre);
  wire hi_up   = ctl_hi[3] & (casc ? lo_ovf : hi_tick & ~ctl_hi[4]);
  wire hi_dn   = ctl_hi[3] & (casc ? lo_udf : hi_tick &  ctl_hi[4]);

  wire src_lo    = sy_lo[1] | (cap_ctl[0] & sy_hi[1]);
  wire src_hi    = sy_hi[1] | (cap_ctl[1] & sy_lo[1]);
  wire cap_ev_lo = edge_hit(ctl_lo[6:5], src_lo, prev_lo);
  wire cap_ev_hi = edge_hit(ctl_hi[6:5], src_hi, prev_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_lo  <= '0;
      ctl_hi  <= '0;
      cap_ctl <= '0;
      pre     <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (wr_en && wr_addr == A_CTL_LO) ctl_lo  <= wr_data[6:0];
      if (wr_en && wr_addr == A_CTL_HI) ctl_hi  <= wr_data[6:0];
      if (wr_en && wr_addr == A_CAPCTL) cap_ctl <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      if (wr_cl)        cnt_lo <= wr_data;
      else if (lo_step) cnt_lo <= ctl_lo[4] ? cnt_lo - 1'b1 : cnt_lo + 1'b1;
      if (wr_ch)        cnt_hi <= wr_data;
      else if (hi_up)   cnt_hi <= cnt_hi + 1'b1;
      else if (hi_dn)   cnt_hi <= cnt_hi - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_lo   <= '0;
      sy_hi   <= '0;
      prev_lo <= 1'b0;
      prev_hi <= 1'b0;
      cap_lo  <= '0;
      cap_hi  <= '0;
    end else begin
      sy_lo   <= {sy_lo[0], cap_pin_lo};
      sy_hi   <= {sy_hi[0], cap_pin_hi};
      prev_lo <= src_lo;
      prev_hi <= src_hi;
      if (cap_ev_lo) cap_lo <= cnt_lo;
      if (cap_ev_hi) cap_hi <= cnt_hi;
    end
  end
endmodule

module cascade_capture_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [6:0]    ctl_lo,
  input logic [6:0]    ctl_hi,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi,
  input logic [CW-1:0] cap_lo,
  input logic          cap_ev_lo
);
  wire w_lo = wr_en && wr_addr == 3'd2;
  wire w_hi = wr_en && wr_addr == 3'd3;
  wire casc = ctl_hi[2:0] == 3'b111;

  // R11
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_lo[3] && !w_lo) |=> $stable(cnt_lo));

  // R5
  casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !w_hi && cnt_lo != '1 && cnt_lo != '0) |=> $stable(cnt_hi));

  // R4
  casc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && ctl_hi[3] && !w_lo && !w_hi && cnt_lo == '1)
      |=> ((cnt_lo == '0) == (cnt_hi == CW'($past(cnt_hi) + 1'b1))));

  // R6
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ev_lo |=> $stable(cap_lo));
endmodule

bind cascade_capture_timer cascade_capture_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctl_lo(ctl_lo), .ctl_hi(ctl_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .cap_lo(cap_lo), .cap_ev_lo(cap_ev_lo)
);

// File: tb/cascade_capture_timer_tb.sv
`timescale 1ns/1ps
module cascade_capture_timer_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, pin_lo = 0, pin_hi = 0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  cascade_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_pin_lo(pin_lo), .cap_pin_hi(pin_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cnt_lo", cnt_lo, 16'h0); chk("R1 cnt_hi", cnt_hi, 16'h0);
    chk("R1 cap_lo", cap_lo, 16'h0); chk("R1 cap_hi", cap_hi, 16'h0);
    waitn(3);
    chk("R1 idle cnt_lo", cnt_lo, 16'h0);
  endtask

  task automatic t_count;
    wr(0, 0); wr(2, 16'd100); wr(0, 16'h0008);
    waitn(7);  chk("R2 up", cnt_lo, 16'd107);
    wr(0, 0); wr(2, 16'd2); wr(0, 16'h0018);
    waitn(3);  chk("R2 down wrap", cnt_lo, 16'hFFFF);
    wr(2, 16'h1234); chk("R10 load priority", cnt_lo, 16'h1234);
    wr(0, 0);
    begin
      logic [15:0] c = cnt_lo;
      waitn(5); chk("R11 hold", cnt_lo, c);
    end
  endtask

  task automatic t_prescale;
    logic [15:0] c;
    wr(0, 0); wr(2, 0); wr(0, 16'h000A);
    c = cnt_lo; waitn(16); chk("R3 sel2", cnt_lo, c + 16'd4);
    wr(0, 16'h000F);
    c = cnt_lo; waitn(256); chk("R3 sel7", cnt_lo, c + 16'd2);
  endtask

  task automatic t_cascade;
    logic [15:0] v;
    wr(0, 0); wr(1, 0); wr(2, 16'hFFFD); wr(3, 16'd5); wr(1, 16'h000F); wr(0, 16'h0008);
    waitn(2); chk("R5 lo", cnt_lo, 16'hFFFF); chk("R5 hi steady", cnt_hi, 16'd5);
    waitn(1); chk("R4 lo wrap", cnt_lo, 16'h0); chk("R4 hi inc", cnt_hi, 16'd6);
    wr(0, 16'h0018);
    v = cnt_lo; waitn(int'(v));
    chk("R5 lo at 0", cnt_lo, 16'h0); chk("R5 hi held", cnt_hi, 16'd6);
    waitn(1); chk("R4 lo under", cnt_lo, 16'hFFFF); chk("R4 hi dec", cnt_hi, 16'd5);
    wr(1, 0);
  endtask

  task automatic t_capture;
    logic [15:0] c, k;
    wr(0, 0); wr(2, 16'd1000); wr(0, 16'h0008);
    c = cnt_lo; pin_lo = 1;
    waitn(2); chk("R6 not yet", cap_lo, 16'h0);
    waitn(1); chk("R9 pre-step value", cap_lo, c + 16'd2);
    wr(0, 16'h0028);
    c = cnt_lo; pin_lo = 0; waitn(3); chk("R7 falling", cap_lo, c + 16'd2);
    k = cap_lo; pin_lo = 1; waitn(4); chk("R7 rising ignored", cap_lo, k);
    wr(0, 16'h0048);
    c = cnt_lo; pin_lo = 0; waitn(3); chk("R7 both fall", cap_lo, c + 16'd2);
    c = cnt_lo; pin_lo = 1; waitn(3); chk("R7 both rise", cap_lo, c + 16'd2);
    c = cnt_lo; pin_lo = 0; waitn(3); chk("R6 return low", cap_lo, c + 16'd2);
  endtask

  task automatic t_capctl;
    logic [15:0] a, b, k;
    wr(0, 16'h0008); wr(1, 0); wr(3, 16'd500); wr(1, 16'h0008); wr(4, 16'h0003);
    a = cnt_lo; b = cnt_hi; pin_hi = 1; waitn(3);
    chk("R8 shared lo", cap_lo, a + 16'd2); chk("R8 shared hi", cap_hi, b + 16'd2);
    wr(4, 0); pin_hi = 0; waitn(3);
    k = cap_lo; b = cnt_hi; pin_hi = 1; waitn(4);
    chk("R8 lo not added", cap_lo, k); chk("R8 hi own pin", cap_hi, b + 16'd2);
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    waitn(3); rst_n = 1; @(negedge clk);
    t_reset; t_count; t_prescale; t_cascade; t_capture; t_capctl;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule